// File: doc/BRIEF.md
# Priority Ingress Rate Limiter

This block polices the frames received on one switch port. Each priority queue has its own byte-credit bucket, so a port can cap traffic separately for each of up to four priorities. The receive path tells the block when a frame starts and gives one strobe for each byte counted. With the start strobe it supplies the frame class and the resolved priority. Once per frame, at its start, the block decides whether the frame is admitted. If it is not, the block either pulses a drop output or raises a pause request, depending on the flow-control setting.

Credit is refilled at a fixed tick in proportion to a 7-bit rate code for each queue. Small codes step in fine increments of 64 kb/s. Larger codes step in increments of 1 Mb/s. Several options shape the policing:
- a class filter decides which frames are policed at all;
- a mode setting folds the four priorities onto two queues;
- a global switch turns per-queue policing off in favour of a single port bucket;
- an accounting option charges preamble and gap bytes on top of the frame bytes.

Top module: `prio_ingress_policer`

## Requirements
- R1: After reset every bucket holds its full depth of 1536 bytes, and `drop` and `pause` are low.
- R2: `type_sel` picks the policed class: 0 = every frame, or else only frames whose `frm_type` equals it (`frm_type` 0 = known unicast, 1 = multicast, 2 = broadcast, 3 = flooded unicast). Frames outside the class are never dropped, never raise pause and consume no credit.
- R3: A policed frame whose bucket holds fewer than 64 bytes at its start is refused. With `fc_en` low, `drop` pulses for one cycle, in the cycle after the `frm_start` cycle. A bucket of 64 bytes or more admits the frame.
- R4: Each `byte_vld` strobe of an admitted policed frame removes one byte from that frame's bucket. The bucket never goes below zero.
- R5: With `len_ovh_en` set, an admitted policed frame is charged 20 extra bytes at its start (8 bytes of preamble and 12 bytes of minimum gap).
- R6: With `fc_en` set, a refused frame is not dropped. Instead `pause` rises in the cycle after `frm_start` and the frame is still charged.
- R7: `pause` stays high until the bucket that raised it holds more than 768 bytes, and falls in the cycle after that happens.
- R8: With `qbased_en` and `four_q` set, priority p uses queue p, and its rate code is `rate_code[7p+6:7p]`.
- R9: With `qbased_en` set and `four_q` clear, priorities 0 and 1 use queue 0 and priorities 2 and 3 use queue 1.
- R10: With `qbased_en` clear, every frame uses queue 0 and its rate code.
- R11: Codes 1 to 15 add code×8 bytes to the bucket per tick, which is 64 kb/s per step at a 1 ms tick.
- R12: Codes from 16 upward add (code−15)×125 bytes per tick, which is 1 Mb/s per step. The bucket saturates at 1536 bytes.
- R13: A queue is unlimited, and never refuses a frame, when its code is 0, or above 115 with `link_100` high, or above 25 with `link_100` low.
- R14: A credit tick happens every `TICK_CYCLES` clocks. The first tick comes on the `TICK_CYCLES`-th rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | One-cycle strobe at the start of a received frame |
| frm_type | input | 2 | Frame class, valid with `frm_start` |
| frm_prio | input | 2 | Resolved priority 0-3, valid with `frm_start` |
| byte_vld | input | 1 | One strobe for each counted frame byte |
| link_100 | input | 1 | 1 = 100 Mb/s link, 0 = 10 Mb/s link |
| rate_code | input | 28 | Four 7-bit rate codes; queue q uses bits [7q+6:7q] |
| type_sel | input | 2 | Policed frame class |
| fc_en | input | 1 | Raise pause instead of dropping |
| four_q | input | 1 | 1 = four queues, 0 = two queues |
| qbased_en | input | 1 | Enable per-queue policing |
| len_ovh_en | input | 1 | Add the 20 bytes of preamble and gap to each frame |
| drop | output | 1 | One-cycle pulse: refuse the current frame |
| pause | output | 1 | Flow-control request |

## Verification
The properties assume that `frm_start` is never high in two consecutive cycles and never coincides with `byte_vld`. They also assume that configuration does not change between a frame's start and the sampling of its decision. The bench keeps to this. Every frame is a single start cycle followed by its byte strobes, an idle cycle separates frames, and configuration is applied only between frames. To make bucket contents exact, each table vector resets the block. It then empties the target bucket by a known amount well before the first tick, so the contents are known without reading any internal state.

// File: rtl/prio_ingress_policer.sv
module prio_ingress_policer #(
  parameter int CODE_W       = 7,
  parameter int DEPTH        = 1536,
  parameter int MIN_CREDIT   = 64,
  parameter int OVH_BYTES    = 20,
  parameter int TICK_CYCLES  = 50000,
  parameter int FINE_LAST    = 15,
  parameter int FINE_BYTES   = 8,
  parameter int COARSE_BYTES = 125,
  parameter int FAST_MBPS    = 100,
  parameter int SLOW_MBPS    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_start,
  input  logic [1:0]        frm_type,
  input  logic [1:0]        frm_prio,
  input  logic              byte_vld,
  input  logic              link_100,
  input  logic [4*CODE_W-1:0] rate_code,
  input  logic [1:0]        type_sel,
  input  logic              fc_en,
  input  logic              four_q,
  input  logic              qbased_en,
  input  logic              len_ovh_en,
  output logic              drop,
  output logic              pause
);
  localparam int NQ   = 4;
  localparam int BW   = $clog2(DEPTH + 1);
  localparam int TW   = $clog2(TICK_CYCLES + 1);
  localparam int HALF = DEPTH / 2;

  logic [TW-1:0]  tcnt;
  logic [BW-1:0]  bkt [NQ];
  logic [BW-1:0]  nxt [NQ];
  logic [NQ-1:0]  unl, pflag;
  logic [1:0]     q, act_q;
  logic           chg, tick, counted, limited, over, admit_chg;

  function automatic int credit_of(input logic [CODE_W-1:0] c);
    if (int'(c) <= FINE_LAST) return int'(c) * FINE_BYTES;
    return (int'(c) - FINE_LAST) * COARSE_BYTES;
  endfunction

  assign tick      = (tcnt == TW'(TICK_CYCLES - 1));
  assign q         = !qbased_en ? 2'd0 : (four_q ? frm_prio : {1'b0, frm_prio[1]});
  assign counted   = (type_sel == 2'd0) || (frm_type == type_sel);
  assign limited   = counted && !unl[q];
  assign over      = bkt[q] < BW'(MIN_CREDIT);
  assign admit_chg = limited && (!over || fc_en);
  assign pause     = |pflag;

  always_comb begin
    for (int i = 0; i < NQ; i++) begin
      logic [CODE_W-1:0] c;
      int nv;
      c      = rate_code[i*CODE_W +: CODE_W];
      unl[i] = (c == '0) ||
               (int'(c) > FINE_LAST + (link_100 ? FAST_MBPS : SLOW_MBPS));
      nv = int'(bkt[i]);
      if (tick) nv = nv + credit_of(c);
      if (byte_vld && chg && act_q == 2'(i)) nv = nv - 1;
      if (frm_start && admit_chg && len_ovh_en && q == 2'(i)) nv = nv - OVH_BYTES;
      if (nv < 0) nv = 0;
      if (nv > DEPTH) nv = DEPTH;
      nxt[i] = BW'(nv);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt  <= '0;
      chg   <= 1'b0;
      act_q <= 2'd0;
      drop  <= 1'b0;
      pflag <= '0;
      for (int i = 0; i < NQ; i++) bkt[i] <= BW'(DEPTH);
    end else begin
      tcnt <= tick ? '0 : tcnt + TW'(1);
      drop <= frm_start && limited && over && !fc_en;
      if (frm_start) begin
        chg   <= admit_chg;
        act_q <= q;
      end
      for (int i = 0; i < NQ; i++) begin
        bkt[i] <= nxt[i];
        if (frm_start && limited && over && fc_en && q == 2'(i))
          pflag[i] <= 1'b1;
        else if (bkt[i] > BW'(HALF))
          pflag[i] <= 1'b0;
      end
    end
  end
endmodule

module policer_props #(
  parameter int CODE_W = 7
) (
  input logic                clk,
  input logic                rst,
  input logic                frm_start,
  input logic [1:0]          frm_type,
  input logic                byte_vld,
  input logic [4*CODE_W-1:0] rate_code,
  input logic [1:0]          type_sel,
  input logic                fc_en,
  input logic                qbased_en,
  input logic                drop,
  input logic                pause
);
  p_start_isolated_r4: assert property (@(posedge clk) disable iff (rst)
    frm_start |-> !byte_vld);
  p_start_gap_r3: assert property (@(posedge clk) disable iff (rst)
    frm_start |=> !frm_start);
  p_drop_follows_start_r3: assert property (@(posedge clk) disable iff (rst)
    drop |-> $past(frm_start));
  p_drop_single_r3: assert property (@(posedge clk) disable iff (rst)
    drop |=> !drop);
  p_fc_no_drop_r6: assert property (@(posedge clk) disable iff (rst)
    frm_start && fc_en |=> !drop);
  p_pause_source_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pause) |-> $past(frm_start && fc_en));
  p_unselected_pass_r2: assert property (@(posedge clk) disable iff (rst)
    frm_start && type_sel != 2'd0 && frm_type != type_sel |=> !drop && !$rose(pause));
  p_code_zero_open_r13: assert property (@(posedge clk) disable iff (rst)
    frm_start && !qbased_en && rate_code[CODE_W-1:0] == '0 |=> !drop);
endmodule

bind prio_ingress_policer policer_props #(.CODE_W(CODE_W)) u_props (
  .clk(clk), .rst(rst), .frm_start(frm_start), .frm_type(frm_type),
  .byte_vld(byte_vld), .rate_code(rate_code), .type_sel(type_sel),
  .fc_en(fc_en), .qbased_en(qbased_en), .drop(drop), .pause(pause)
);

// File: tb/prio_ingress_policer_test.sv
module prio_ingress_policer_test;
  localparam int T = 3000;

  logic clk = 1'b0, rst = 1'b1;
  logic frm_start = 0, byte_vld = 0, link_100 = 1, fc_en = 0, four_q = 1;
  logic qbased_en = 1, len_ovh_en = 0;
  logic [1:0] frm_type = 0, frm_prio = 0, type_sel = 0;
  logic [27:0] rate_code = {4{7'd1}};
  logic drop, pause;
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_ingress_policer #(.TICK_CYCLES(T)) uut (
    .clk(clk), .rst(rst), .frm_start(frm_start), .frm_type(frm_type),
    .frm_prio(frm_prio), .byte_vld(byte_vld), .link_100(link_100),
    .rate_code(rate_code), .type_sel(type_sel), .fc_en(fc_en),
    .four_q(four_q), .qbased_en(qbased_en), .len_ovh_en(len_ovh_en),
    .drop(drop), .pause(pause));

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  // {rq4, qen, fourq, drain_prio2, drain_len11, ovh, test_prio2, ftype2, sel2, spd, fc, code7, exp_drop, exp_pause}
  localparam logic [36:0] VEC [22] = '{
    {4'd3,  1'b1,1'b1,2'd0,11'd1536,1'b0,2'd0,2'd0,2'd0,1'b1,1'b0,7'd1,  1'b1,1'b0}, // R3 empty
    {4'd4,  1'b1,1'b1,2'd0,11'd1472,1'b0,2'd0,2'd0,2'd0,1'b1,1'b0,7'd1,  1'b0,1'b0}, // R4 64 left
    {4'd4,  1'b1,1'b1,2'd0,11'd1473,1'b0,2'd0,2'd0,2'd0,1'b1,1'b0,7'd1,  1'b1,1'b0}, // R4 63 left
    {4'd5,  1'b1,1'b1,2'd0,11'd1452,1'b1,2'd0,2'd0,2'd0,1'b1,1'b0,7'd1,  1'b0,1'b0}, // R5
    {4'd5,  1'b1,1'b1,2'd0,11'd1453,1'b1,2'd0,2'd0,2'd0,1'b1,1'b0,7'd1,  1'b1,1'b0}, // R5
    {4'd6,  1'b1,1'b1,2'd0,11'd1536,1'b0,2'd0,2'd0,2'd0,1'b1,1'b1,7'd1,  1'b0,1'b1}, // R6
    {4'd8,  1'b1,1'b1,2'd0,11'd1536,1'b0,2'd1,2'd0,2'd0,1'b1,1'b0,7'd1,  1'b0,1'b0}, // R8
    {4'd8,  1'b1,1'b1,2'd3,11'd1536,1'b0,2'd3,2'd0,2'd0,1'b1,1'b0,7'd1,  1'b1,1'b0}, // R8
    {4'd9,  1'b1,1'b0,2'd0,11'd1536,1'b0,2'd1,2'd0,2'd0,1'b1,1'b0,7'd1,  1'b1,1'b0}, // R9
    {4'd9,  1'b1,1'b0,2'd1,11'd1536,1'b0,2'd2,2'd0,2'd0,1'b1,1'b0,7'd1,  1'b0,1'b0}, // R9
    {4'd9,  1'b1,1'b0,2'd2,11'd1536,1'b0,2'd3,2'd0,2'd0,1'b1,1'b0,7'd1,  1'b1,1'b0}, // R9
    {4'd10, 1'b0,1'b1,2'd0,11'd1536,1'b0,2'd3,2'd0,2'd0,1'b1,1'b0,7'd1,  1'b1,1'b0}, // R10
    {4'd2,  1'b1,1'b1,2'd0,11'd1536,1'b0,2'd0,2'd2,2'd1,1'b1,1'b0,7'd1,  1'b0,1'b0}, // R2
    {4'd2,  1'b1,1'b1,2'd0,11'd1536,1'b0,2'd0,2'd1,2'd1,1'b1,1'b0,7'd1,  1'b1,1'b0}, // R2
    {4'd2,  1'b1,1'b1,2'd0,11'd1536,1'b0,2'd0,2'd2,2'd2,1'b1,1'b0,7'd1,  1'b1,1'b0}, // R2
    {4'd2,  1'b1,1'b1,2'd0,11'd1536,1'b0,2'd0,2'd3,2'd3,1'b1,1'b0,7'd1,  1'b1,1'b0}, // R2
    {4'd2,  1'b1,1'b1,2'd0,11'd1536,1'b0,2'd0,2'd0,2'd3,1'b1,1'b0,7'd1,  1'b0,1'b0}, // R2
    {4'd13, 1'b1,1'b1,2'd0,11'd1536,1'b0,2'd0,2'd0,2'd0,1'b1,1'b0,7'd0,  1'b0,1'b0}, // R13
    {4'd13, 1'b1,1'b1,2'd0,11'd1536,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0,7'd30, 1'b0,1'b0}, // R13
    {4'd13, 1'b1,1'b1,2'd0,11'd1536,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0,7'd25, 1'b1,1'b0}, // R13
    {4'd13, 1'b1,1'b1,2'd0,11'd1536,1'b0,2'd0,2'd0,2'd0,1'b1,1'b0,7'd115,1'b1,1'b0}, // R13
    {4'd13, 1'b1,1'b1,2'd0,11'd1536,1'b0,2'd0,2'd0,2'd0,1'b1,1'b0,7'd116,1'b0,1'b0}  // R13
  };

  task automatic chk(input string rq, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(input logic [1:0] p, input logic [1:0] ft, input int n,
                      output logic d, output logic ps);
    @(negedge clk);
    frm_prio = p; frm_type = ft; frm_start = 1'b1;
    @(negedge clk);
    frm_start = 1'b0;
    d = drop; ps = pause;
    for (int i = 0; i < n; i++) begin
      byte_vld = 1'b1;
      @(negedge clk);
    end
    byte_vld = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic base_cfg();
    type_sel = 0; fc_en = 0; link_100 = 1; len_ovh_en = 0;
    qbased_en = 1; four_q = 1; rate_code = {4{7'd1}};
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic d, p;
    string rq;
    base_cfg();
    do_reset();
    // R1: reset state and a full bucket
    @(negedge clk);
    chk("R1", drop, 1'b0);
    chk("R1", pause, 1'b0);
    send(2'd0, 2'd0, 1472, d, p);
    chk("R1", d, 1'b0);
    send(2'd0, 2'd0, 0, d, p);
    chk("R1", d, 1'b0);

    foreach (VEC[k]) begin
      logic [36:0] v;
      v = VEC[k];
      base_cfg();
      qbased_en = v[32]; four_q = v[31]; len_ovh_en = v[17];
      do_reset();
      send(v[30:29], 2'd0, int'(v[28:18]), d, p);
      type_sel = v[12:11]; link_100 = v[10]; fc_en = v[9];
      rate_code = {4{v[8:2]}};
      send(v[16:15], v[14:13], 0, d, p);
      rq = $sformatf("R%0d vec%0d drop", v[36:33], k);
      chk(rq, d, v[1]);
      rq = $sformatf("R%0d vec%0d pause", v[36:33], k);
      chk(rq, p, v[0]);
    end

    // R14: no credit before the first tick
    base_cfg(); do_reset();
    send(2'd0, 2'd0, 1536, d, p);
    rate_code = {4{7'd8}};
    wait_cyc(T - 3);
    send(2'd0, 2'd0, 0, d, p);
    chk("R14", d, 1'b1);
    // R11: code 8 adds 64 bytes on the tick
    wait_cyc(T + 2);
    send(2'd0, 2'd0, 0, d, p);
    chk("R11", d, 1'b0);
    // R11: code 7 gives 56, then 112 after two ticks
    base_cfg(); do_reset();
    send(2'd0, 2'd0, 1536, d, p);
    rate_code = {4{7'd7}};
    wait_cyc(T + 2);
    send(2'd0, 2'd0, 0, d, p);
    chk("R11", d, 1'b1);
    wait_cyc(2 * T + 2);
    send(2'd0, 2'd0, 0, d, p);
    chk("R11", d, 1'b0);

    // R6 / R7 / R12: pause with code 17 (250 bytes per tick)
    base_cfg(); do_reset();
    send(2'd0, 2'd0, 1536, d, p);
    rate_code = {4{7'd17}}; fc_en = 1;
    send(2'd0, 2'd0, 0, d, p);
    chk("R6 drop", d, 1'b0);
    chk("R6 pause", p, 1'b1);
    wait_cyc(3 * T + 10);
    chk("R7 held at 750", pause, 1'b1);
    wait_cyc(4 * T + 10);
    chk("R7 released at 1000", pause, 1'b0);

    // R12: saturation at 1536
    base_cfg(); do_reset();
    send(2'd0, 2'd0, 1536, d, p);
    rate_code = {4{7'd115}};
    wait_cyc(T + 2);
    send(2'd0, 2'd0, 1473, d, p);
    chk("R12 admit", d, 1'b0);
    send(2'd0, 2'd0, 0, d, p);
    chk("R12 cap", d, 1'b1);

    // R2: unselected frame consumes nothing
    base_cfg(); do_reset();
    type_sel = 2'd1;
    send(2'd0, 2'd2, 1536, d, p);
    chk("R2 unselected", d, 1'b0);
    send(2'd0, 2'd1, 0, d, p);
    chk("R2 credit intact", d, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule